// File: doc/BRIEF.md
# Board System Control Register Bank

This block is a bank of 32-bit control and status registers behind a plain synchronous register bus that decodes a 4 KB byte-address window. Software uses it to set a handful of board-level configuration words, to drive a remap strobe and a row of LEDs, and to inspect the lock state of the board's delay-locked loops through a status word with a software-owned lock mask.

Which general configuration slots exist, and whether the remap and LED outputs follow software, is set by a 12-bit part number carried in the fixed identification word. The identification word is a parameter, so one source serves every board variant. Any access to an offset that the current variant does not decode reads back zero, changes nothing, and raises a bad-access pulse. Read data is registered and appears one cycle after the read request. A write takes effect on the clock edge that samples it.

Top module: `sys_ctrl_regs`

## Requirements
- R1: After reset, slot 0 (offset 0x00) holds the parameter CFG0_RST. Slots 1, 2, 5, 6 and 7 (offsets 0x04, 0x08, 0x14, 0x18, 0x1C) hold zero. The DLL word at 0x100 reads 0xFFFF0001 while all eight locked inputs are high. bad_access is low.
- R2: Writable slots (0, 1, 2, 5, 6, 7, where present) store all 32 bits. A read with bus_rd high at clock edge N presents the data on bus_rdata after edge N, and bus_rdata holds that value until the next read.
- R3: The part number is bits [15:4] of the ID word. Slots 2 and 5 exist only for parts 0x524, 0x547 and 0x536. Slot 3 exists only for all other parts. Slot 6 exists only for 0x524 and 0x536. Slot 7 exists only for 0x536. Slots 0, 1 and 4, the DLL word, AID (0xFF8) and ID (0xFFC) always exist.
- R4: A read of an absent slot, an unmapped offset or an offset with nonzero bits [1:0] returns zero. A write to any of these, or to a read-only word, changes no state.
- R5: bad_access is high for exactly the one cycle after the edge that samples such an access. Writes to the read-only words (slot 3, slot 4, AID, ID) also count as bad accesses.
- R6: Slot 3 reads zero. Slot 4, AID and ID read the parameters CFG4_VAL, AID_VAL and ID_VAL.
- R7: For every part other than 0x536, remap equals bit 0 of slot 0 and leds[i] equals bit i of slot 1 (active high). For part 0x536, remap and leds stay zero.
- R8: In the DLL word, only bits [31:24] (the lock mask) are writable, and they reset to 0xFF. Bits [23:16] mirror dll_locked. Bits [15:1] read zero. Bit 0 reads 1 exactly when every dll_locked bit whose mask bit is set is high.
- R9: A write to slot 0 or slot 1 is visible on remap and leds right after the edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle pulse after an access to an absent, unmapped or read-only word |
| dll_locked | input | 8 | Per-DLL lock status |
| remap | output | 1 | Remap control from slot 0 bit 0 |
| leds | output | LED_N | LED drive from the low bits of slot 1 |

## Verification
A wrong decision about whether a slot is present shows up one cycle after the access, either as a nonzero read where zero belongs or as a missing or spurious bad_access pulse. Corrupted slot contents reach the pins only through a later read, except for slots 0 and 1, whose low bits appear on remap and leds directly after the writing edge. A wrong lock mask, or a wrong combination of mask and locked bits, shows up in DLL bit 0 on the next read of the DLL word. The bench drives three variants on one bus so that each presence rule is seen from both sides.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int REG_W  = 32;
  localparam int SLOTS  = 8;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int DLL_N  = 8;

  localparam int OFS_DLL = 32'h100;
  localparam int OFS_AID = 32'hFF8;
  localparam int OFS_ID  = 32'hFFC;

  localparam logic [11:0] PN_A   = 12'h524;
  localparam logic [11:0] PN_B   = 12'h547;
  localparam logic [11:0] PN_ALT = 12'h536;

  // slots that software may write, when present
  localparam logic [SLOTS-1:0] WRITABLE = 8'b1110_0111;

  typedef enum logic [1:0] {SRC_SLOT, SRC_DLL, SRC_AID, SRC_ID} src_e;

  function automatic logic [SLOTS-1:0] present_mask(input logic [11:0] pn);
    logic wide;
    logic [SLOTS-1:0] m;
    wide = (pn == PN_A) || (pn == PN_B) || (pn == PN_ALT);
    m = 8'b0001_0011;
    if (wide) m = m | 8'b0010_0100;
    else      m = m | 8'b0000_1000;
    if ((pn == PN_A) || (pn == PN_ALT)) m[6] = 1'b1;
    if (pn == PN_ALT) m[7] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int               ADDR_W  = 12,
  parameter logic [SLOTS-1:0] PRESENT = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              hit,
  output src_e              src,
  output logic [SLOT_W-1:0] idx,
  output logic              slot_we,
  output logic              dll_we
);
  always_comb begin
    hit = 1'b0;
    src = SRC_SLOT;
    idx = addr[SLOT_W+1:2];
    if (addr[1:0] == 2'b00) begin
      if (addr < ADDR_W'(SLOTS * 4)) begin
        hit = PRESENT[idx] && (!wr || WRITABLE[idx]);
      end else if (addr == ADDR_W'(OFS_DLL)) begin
        hit = 1'b1;
        src = SRC_DLL;
      end else if (addr == ADDR_W'(OFS_AID)) begin
        hit = !wr;
        src = SRC_AID;
      end else if (addr == ADDR_W'(OFS_ID)) begin
        hit = !wr;
        src = SRC_ID;
      end
    end
  end

  assign slot_we = wr && hit && (src == SRC_SLOT);
  assign dll_we  = wr && hit && (src == SRC_DLL);

  // rd only qualifies the bus; decode itself is address driven
  logic unused_rd;
  assign unused_rd = rd;
endmodule

// File: rtl/sysctl_cfg_bank.sv
module sysctl_cfg_bank
  import sysctl_pkg::*;
#(
  parameter logic [SLOTS-1:0] PRESENT  = '1,
  parameter logic [REG_W-1:0] CFG0_RST = '0,
  parameter logic [REG_W-1:0] CFG4_VAL = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [SLOT_W-1:0]           idx,
  input  logic [REG_W-1:0]            wdata,
  output logic [SLOTS-1:0][REG_W-1:0] vals
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (WRITABLE[i] && PRESENT[i]) begin : g_rw
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                               q <= (i == 0) ? CFG0_RST : '0;
        else if (we && (idx == SLOT_W'(i)))    q <= wdata;
      end
      assign vals[i] = q;
    end else if (i == 4) begin : g_const
      assign vals[i] = CFG4_VAL;
    end else begin : g_zero
      assign vals[i] = '0;
    end
  end
endmodule

// File: rtl/sysctl_dll.sv
module sysctl_dll
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [DLL_N-1:0] mask_in,
  input  logic [DLL_N-1:0] locked,
  output logic [REG_W-1:0] value
);
  localparam int GAP = REG_W - 2 * DLL_N - 1;

  logic [DLL_N-1:0] mask_q;
  logic             all_ok;

  always_ff @(posedge clk) begin
    if (rst)     mask_q <= '1;
    else if (we) mask_q <= mask_in;
  end

  assign all_ok = &(locked | ~mask_q);
  assign value  = {mask_q, locked, {GAP{1'b0}}, all_ok};

  // mask moves only through an accepted DLL write
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mask_q));
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sysctl_pkg::*;
#(
  parameter int               ADDR_W   = 12,
  parameter int               LED_N    = 8,
  parameter logic [REG_W-1:0] CFG0_RST = 32'h0000_0000,
  parameter logic [REG_W-1:0] CFG4_VAL = 32'h0000_0000,
  parameter logic [REG_W-1:0] AID_VAL  = 32'h0000_0000,
  parameter logic [REG_W-1:0] ID_VAL   = 32'h4104_5240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bad_access,
  input  logic [DLL_N-1:0]  dll_locked,
  output logic              remap,
  output logic [LED_N-1:0]  leds
);
  localparam logic [11:0]      PART    = ID_VAL[15:4];
  localparam logic [SLOTS-1:0] PRESENT = present_mask(PART);
  localparam bit               ALT     = (PART == PN_ALT);

  logic                        hit, slot_we, dll_we;
  src_e                        src;
  logic [SLOT_W-1:0]           idx;
  logic [SLOTS-1:0][REG_W-1:0] vals;
  logic [REG_W-1:0]            dll_val, rd_mux;

  sysctl_decode #(.ADDR_W(ADDR_W), .PRESENT(PRESENT)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .hit(hit), .src(src), .idx(idx), .slot_we(slot_we), .dll_we(dll_we)
  );

  sysctl_cfg_bank #(.PRESENT(PRESENT), .CFG0_RST(CFG0_RST), .CFG4_VAL(CFG4_VAL)) u_bank (
    .clk(clk), .rst(rst), .we(slot_we), .idx(idx), .wdata(bus_wdata), .vals(vals)
  );

  sysctl_dll u_dll (
    .clk(clk), .rst(rst), .we(dll_we),
    .mask_in(bus_wdata[REG_W-1 -: DLL_N]), .locked(dll_locked), .value(dll_val)
  );

  always_comb begin
    case (src)
      SRC_DLL: rd_mux = dll_val;
      SRC_AID: rd_mux = AID_VAL;
      SRC_ID:  rd_mux = ID_VAL;
      default: rd_mux = vals[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bad_access <= 1'b0;
    end else begin
      bad_access <= (bus_rd || bus_wr) && !hit;
      if (bus_rd) bus_rdata <= hit ? rd_mux : '0;
    end
  end

  if (ALT) begin : g_out_alt
    assign remap = 1'b0;
    assign leds  = '0;
  end else begin : g_out_std
    assign remap = vals[0][0];
    assign leds  = vals[1][LED_N-1:0];
  end

  // a rejected access leaves the driven outputs untouched
  assert_bad_no_effect_R4: assert property (@(posedge clk) disable iff (rst)
    bad_access |-> ($stable(remap) && $stable(leds)));

  // a rejected read returns zero
  assert_bad_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bad_access && $past(bus_rd)) |-> (bus_rdata == '0));

  // the flag only follows a real bus access
  assert_bad_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
    bad_access |-> $past(bus_rd || bus_wr));

  // identification word is constant
  assert_id_read_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(OFS_ID)) |=> (bus_rdata == ID_VAL));
endmodule

// File: tb/tb_sys_ctrl_regs.sv
module tb_sys_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_A   = 32'h4104_5240;  // part 0x524
  localparam logic [31:0] ID_ALT = 32'h4104_5360;  // part 0x536
  localparam logic [31:0] ID_OTH = 32'h4104_5110;  // part 0x511
  localparam logic [31:0] AIDV   = 32'h0200_0008;
  localparam logic [31:0] C4V    = 32'h0000_0003;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  dll_locked = 8'hFF;

  logic [31:0] rd_a, rd_b, rd_c;
  logic        bad_a, bad_b, bad_c, rm_a, rm_b, rm_c;
  logic [7:0]  led_a, led_b, led_c;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_ctrl_regs #(.CFG0_RST(32'h1), .CFG4_VAL(C4V), .AID_VAL(AIDV), .ID_VAL(ID_A)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .bad_access(bad_a),
    .dll_locked(dll_locked), .remap(rm_a), .leds(led_a));

  sys_ctrl_regs #(.CFG4_VAL(C4V), .AID_VAL(AIDV), .ID_VAL(ID_ALT)) dut_alt (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .bad_access(bad_b),
    .dll_locked(dll_locked), .remap(rm_b), .leds(led_b));

  sys_ctrl_regs #(.CFG4_VAL(C4V), .AID_VAL(AIDV), .ID_VAL(ID_OTH)) dut_oth (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rd_c), .bad_access(bad_c),
    .dll_locked(dll_locked), .remap(rm_c), .leds(led_c));

  // {write, addr, wdata, expected read, expected bad} for dut (part 0x524)
  localparam int NV = 24;
  localparam logic [77:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'hA5A5_0001, 32'h0,          1'b0},
    {1'b0, 12'h000, 32'h0,         32'hA5A5_0001,  1'b0},
    {1'b1, 12'h004, 32'h0000_00C3, 32'h0,          1'b0},
    {1'b0, 12'h004, 32'h0,         32'h0000_00C3,  1'b0},
    {1'b1, 12'h008, 32'h1234_5678, 32'h0,          1'b0},
    {1'b0, 12'h008, 32'h0,         32'h1234_5678,  1'b0},
    {1'b1, 12'h014, 32'hCAFE_F00D, 32'h0,          1'b0},
    {1'b0, 12'h014, 32'h0,         32'hCAFE_F00D,  1'b0},
    {1'b1, 12'h018, 32'h0BAD_BEEF, 32'h0,          1'b0},
    {1'b0, 12'h018, 32'h0,         32'h0BAD_BEEF,  1'b0},
    {1'b1, 12'h01C, 32'hFFFF_FFFF, 32'h0,          1'b1},
    {1'b0, 12'h01C, 32'h0,         32'h0,          1'b1},
    {1'b0, 12'h00C, 32'h0,         32'h0,          1'b1},
    {1'b1, 12'h010, 32'h0000_0001, 32'h0,          1'b1},
    {1'b0, 12'h010, 32'h0,         C4V,            1'b0},
    {1'b0, 12'h200, 32'h0,         32'h0,          1'b1},
    {1'b1, 12'h200, 32'h0000_0001, 32'h0,          1'b1},
    {1'b0, 12'h002, 32'h0,         32'h0,          1'b1},
    {1'b0, 12'hFF8, 32'h0,         AIDV,           1'b0},
    {1'b0, 12'hFFC, 32'h0,         ID_A,           1'b0},
    {1'b1, 12'hFFC, 32'h0,         32'h0,          1'b1},
    {1'b0, 12'hFFC, 32'h0,         ID_A,           1'b0},
    {1'b1, 12'h100, 32'h00FF_FFFF, 32'h0,          1'b0},
    {1'b0, 12'h100, 32'h0,         32'h00FF_0001,  1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = !w; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    check("R1 bad idle", {31'b0, bad_a}, 32'h0);
    check("R1 remap from CFG0_RST", {31'b0, rm_a}, 32'h1);
    check("R1 leds reset", {24'b0, led_a}, 32'h0);
    access(1'b0, 12'h000, 0); check("R1 slot0 reset", rd_a, 32'h1);
    check("R1 slot0 reset alt", rd_b, 32'h0);
    access(1'b0, 12'h004, 0); check("R1 slot1 reset", rd_a, 32'h0);
    access(1'b0, 12'h008, 0); check("R1 slot2 reset", rd_a, 32'h0);
    access(1'b0, 12'h014, 0); check("R1 slot5 reset", rd_a, 32'h0);
    access(1'b0, 12'h018, 0); check("R1 slot6 reset", rd_a, 32'h0);
    access(1'b0, 12'h01C, 0); check("R1 slot7 reset alt", rd_b, 32'h0);
    access(1'b0, 12'h100, 0); check("R1 dll reset", rd_a, 32'hFFFF_0001);

    // table walk on the 0x524 variant
    for (int i = 0; i < NV; i++) begin
      logic        w;
      logic [11:0] a;
      logic [31:0] d, e;
      logic        b;
      {w, a, d, e, b} = VEC[i];
      access(w, a, d);
      check(b ? "R5 table flag" : "R5 table no flag", {31'b0, bad_a}, {31'b0, b});
      if (!w) check(b ? "R4 table zero read" : "R2 table read", rd_a, e);
    end

    // R5: flag lasts one cycle
    access(1'b0, 12'h300, 0);
    check("R5 flag set", {31'b0, bad_a}, 32'h1);
    @(negedge clk);
    check("R5 flag one cycle", {31'b0, bad_a}, 32'h0);

    // R7/R9: outputs after the table writes
    check("R7 remap follows slot0", {31'b0, rm_a}, 32'h1);
    check("R7 leds follow slot1", {24'b0, led_a}, 32'hC3);
    check("R7 alt remap quiet", {31'b0, rm_b}, 32'h0);
    check("R7 alt leds quiet", {24'b0, led_b}, 32'h0);
    access(1'b1, 12'h000, 32'hFFFF_FFFE);
    check("R9 remap drops after write", {31'b0, rm_a}, 32'h0);
    access(1'b1, 12'h004, 32'h0000_015A);
    check("R9 leds update after write", {24'b0, led_a}, 32'h5A);
    check("R9 other variant leds", {24'b0, led_c}, 32'h5A);
    check("R7 alt leds stay zero", {24'b0, led_b}, 32'h0);
    access(1'b1, 12'h000, 32'h1);
    check("R7 alt remap stays zero", {31'b0, rm_b}, 32'h0);
    check("R9 remap rises", {31'b0, rm_a}, 32'h1);

    // R3: presence across variants
    access(1'b0, 12'h01C, 0);
    check("R3 alt slot7 kept", rd_b, 32'hFFFF_FFFF);
    check("R3 alt slot7 no flag", {31'b0, bad_b}, 32'h0);
    check("R3 other slot7 absent", {31'b0, bad_c}, 32'h1);
    access(1'b0, 12'h00C, 0);
    check("R3 R6 other slot3 zero", rd_c, 32'h0);
    check("R3 other slot3 present", {31'b0, bad_c}, 32'h0);
    check("R3 alt slot3 absent", {31'b0, bad_b}, 32'h1);
    access(1'b0, 12'h008, 0);
    check("R3 R4 other slot2 absent", rd_c, 32'h0);
    check("R3 other slot2 flag", {31'b0, bad_c}, 32'h1);
    access(1'b0, 12'h018, 0);
    check("R3 alt slot6", rd_b, 32'h0BAD_BEEF);
    check("R3 other slot6 absent", {31'b0, bad_c}, 32'h1);

    // R8: mask and summary
    access(1'b1, 12'h100, 32'h0F12_3456);
    dll_locked = 8'hF0;
    access(1'b0, 12'h100, 0);
    check("R8 masked unlocked", rd_a, 32'h0FF0_0000);
    dll_locked = 8'h0F;
    access(1'b0, 12'h100, 0);
    check("R8 masked locked", rd_a, 32'h0F0F_0001);
    dll_locked = 8'h00;
    access(1'b1, 12'h100, 32'h0);
    access(1'b0, 12'h100, 0);
    check("R8 empty mask", rd_a, 32'h0000_0001);
    @(negedge clk);
    check("R2 rdata holds", rd_a, 32'h0000_0001);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule